// File: doc/BRIEF.md
# Pause Frame Receive Detector

This block watches the receive byte stream of an Ethernet port and recognises flow-control pause frames on the fly. Each byte arrives with a valid strobe. A start marker is set on the first byte of a frame, an end marker on the last, and an error marker on any byte the line decoder found corrupt. The block compares the destination address, the type field and the control opcode byte by byte as they go past, so it never stores the whole frame. It also collects the two pause-time bytes that follow the opcode.

One cycle after the last byte it reports a verdict. A frame-done pulse always comes out, together with a deliver/drop flag for the downstream receive path. When the frame is an intact pause frame and the block is set to act on it, a single-cycle pause request goes to the transmitter and carries the 16-bit quanta value. A forward-enable input selects the other behaviour: pause frames are handed on to software and the transmitter gets no request. In half-duplex operation pause frames are treated as ordinary traffic.

Top module: `pause_rx_detect`

## Requirements
- R1: A frame whose first six bytes equal `station_addr` (bits 47:40 on the first byte, bits 7:0 on the sixth) passes the destination check.
- R2: A frame whose first six bytes are 01, 80, C2, 00, 00, 01 passes the destination check. Any other destination fails it.
- R3: Bytes 12 and 13 (counting from 0) must be 0x88 then 0x08, otherwise the frame is not a pause frame.
- R4: Bytes 14 and 15 must be 0x00 then 0x01, otherwise the frame is not a pause frame.
- R5: Bytes 16 and 17 form the pause time, byte 16 being the most significant. The value is presented on `pause_quanta` in the same cycle as `pause_req`.
- R6: `frame_done` pulses for one cycle in the cycle after the byte carrying `rx_eof` is accepted. `pause_req` can only pulse together with it, and only if `crc_ok` was high with that last byte and no byte of the frame carried `rx_err`.
- R7: With `fwd_en` low and `full_duplex` high, an intact pause frame gives `pause_req`=1 and `frame_deliver`=0.
- R8: With `fwd_en` high, an intact pause frame gives `frame_deliver`=1 and `pause_req`=0.
- R9: With `full_duplex` low, no frame raises `pause_req` and every frame is delivered.
- R10: A frame shorter than 18 bytes, or one failing any check of R1 to R6, is delivered (`frame_deliver`=1) and raises no request.
- R11: During and straight after reset, `pause_req`, `frame_done`, `frame_deliver` and `pause_quanta` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Byte received with a line error |
| crc_ok | input | 1 | Frame check sequence good, sampled with the last byte |
| station_addr | input | 48 | Local station address |
| fwd_en | input | 1 | 1: pass pause frames on to software and take no action |
| full_duplex | input | 1 | 1: full-duplex link, pause frames are honoured |
| pause_req | output | 1 | One-cycle pause request to the transmitter |
| pause_quanta | output | 16 | Requested pause time, valid with `pause_req` |
| frame_done | output | 1 | One-cycle verdict strobe after each frame |
| frame_deliver | output | 1 | With `frame_done`: 1 deliver, 0 drop |

## Verification
A match flag that gets stuck, or one that is not rearmed by the start marker, shows up in the verdict on the very next frame. A pause frame is then dropped or delivered wrongly, or a missed request shows a mismatched `frame_deliver` one cycle after that frame's last byte. A byte counter that is off by one moves the quanta capture, so `pause_quanta` holds a neighbouring byte at the first request. A stale error flag suppresses the request of the frame that follows a corrupt one. Random frames with idle gaps, random configuration and near-miss headers are run against directed corner cases, so each of these faults appears within a few frames.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned TYPE_POS   = 12;
  localparam int unsigned OP_POS     = 14;
  localparam int unsigned QT_POS     = 16;
  localparam logic [47:0] PAUSE_GROUP = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_TYPE   = 16'h8808;
  localparam logic [15:0] PAUSE_OP    = 16'h0001;

  typedef struct packed {
    logic        ucast;
    logic        mcast;
    logic        typ;
    logic        op;
    logic        len;
    logic        err;
    logic [15:0] qt;
  } pfd_flags_t;
endpackage

// File: rtl/pfd_addr_match.sv
module pfd_addr_match #(
  parameter int unsigned NBYTES = 6,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [IDX_W-1:0]    pos,
  input  logic [7:0]          data,
  input  logic                restart,
  input  logic [8*NBYTES-1:0] station,
  input  logic [8*NBYTES-1:0] group,
  input  logic                ucast_q,
  input  logic                mcast_q,
  output logic                ucast_d,
  output logic                mcast_d
);
  logic [7:0] st_b [NBYTES];
  logic [7:0] gr_b [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_split
    assign st_b[g] = station[8*(NBYTES-g)-1 -: 8];
    assign gr_b[g] = group[8*(NBYTES-g)-1 -: 8];
  end

  always_comb begin
    ucast_d = restart ? 1'b1 : ucast_q;
    mcast_d = restart ? 1'b1 : mcast_q;
    for (int k = 0; k < NBYTES; k++) begin
      if (pos == IDX_W'(k)) begin
        ucast_d = ucast_d & (data == st_b[k]);
        mcast_d = mcast_d & (data == gr_b[k]);
      end
    end
  end
endmodule

// File: rtl/pfd_field_track.sv
module pfd_field_track
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_LEN = 18,
  parameter int unsigned IDX_W   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_err,
  input  logic [47:0] station,
  output pfd_flags_t  flg_d
);
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
  pfd_flags_t       flg_q;
  logic             uc_d, mc_d;

  assign cur_idx = in_sof ? '0 : idx_q;

  pfd_addr_match #(.NBYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_addr (
    .pos(cur_idx), .data(in_data), .restart(in_sof),
    .station(station), .group(PAUSE_GROUP),
    .ucast_q(flg_q.ucast), .mcast_q(flg_q.mcast),
    .ucast_d(uc_d), .mcast_d(mc_d)
  );

  always_comb begin
    idx_d = idx_q;
    flg_d = flg_q;
    if (in_valid) begin
      idx_d = (cur_idx >= IDX_W'(MIN_LEN)) ? cur_idx : cur_idx + 1'b1;
      flg_d.ucast = uc_d;
      flg_d.mcast = mc_d;
      flg_d.typ   = in_sof ? 1'b1 : flg_q.typ;
      flg_d.op    = in_sof ? 1'b1 : flg_q.op;
      flg_d.len   = in_sof ? 1'b0 : flg_q.len;
      flg_d.err   = (in_sof ? 1'b0 : flg_q.err) | in_err;
      if (cur_idx == IDX_W'(TYPE_POS))   flg_d.typ = flg_d.typ & (in_data == CTRL_TYPE[15:8]);
      if (cur_idx == IDX_W'(TYPE_POS+1)) flg_d.typ = flg_d.typ & (in_data == CTRL_TYPE[7:0]);
      if (cur_idx == IDX_W'(OP_POS))     flg_d.op  = flg_d.op & (in_data == PAUSE_OP[15:8]);
      if (cur_idx == IDX_W'(OP_POS+1))   flg_d.op  = flg_d.op & (in_data == PAUSE_OP[7:0]);
      if (cur_idx == IDX_W'(QT_POS))     flg_d.qt[15:8] = in_data;
      if (cur_idx == IDX_W'(QT_POS+1))   flg_d.qt[7:0]  = in_data;
      if (cur_idx == IDX_W'(MIN_LEN-1))  flg_d.len = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      flg_q <= '0;
    end else if (in_valid) begin
      idx_q <= idx_d;
      flg_q <= flg_d;
    end
  end

  // R10
  idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(MIN_LEN));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && flg_q.err) |=> flg_q.err);
endmodule

// File: rtl/pfd_decide.sv
module pfd_decide
  import pfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fin,
  input  pfd_flags_t  flg,
  input  logic        crc_ok,
  input  logic        fwd_en,
  input  logic        full_duplex,
  output logic        pause_req,
  output logic [15:0] pause_quanta,
  output logic        frame_done,
  output logic        frame_deliver
);
  logic        is_pause, req_d, del_d;
  logic [15:0] qt_d;

  always_comb begin
    is_pause = flg.len & (flg.ucast | flg.mcast) & flg.typ & flg.op
             & ~flg.err & crc_ok & full_duplex;
    req_d    = fin & is_pause & ~fwd_en;
    del_d    = fin & ~(is_pause & ~fwd_en);
    qt_d     = req_d ? flg.qt : pause_quanta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_req     <= 1'b0;
      frame_done    <= 1'b0;
      frame_deliver <= 1'b0;
      pause_quanta  <= '0;
    end else begin
      pause_req     <= req_d;
      frame_done    <= fin;
      frame_deliver <= del_d;
      pause_quanta  <= qt_d;
    end
  end

  // R6
  req_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> (frame_done && !frame_deliver));
  // R6
  done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> frame_done);
  // R8
  fwd_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fwd_en) |=> !pause_req);
  // R9
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !full_duplex) |=> (frame_deliver && !pause_req));
  // R5
  quanta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_d) |=> $stable(pause_quanta));
endmodule

// File: rtl/pause_rx_detect.sv
module pause_rx_detect
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_LEN = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic        crc_ok,
  input  logic [47:0] station_addr,
  input  logic        fwd_en,
  input  logic        full_duplex,
  output logic        pause_req,
  output logic [15:0] pause_quanta,
  output logic        frame_done,
  output logic        frame_deliver
);
  localparam int unsigned IDX_W = $clog2(MIN_LEN + 1);

  pfd_flags_t flg_d;
  logic       fin;

  assign fin = rx_valid & rx_eof;

  pfd_field_track #(.MIN_LEN(MIN_LEN), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .in_sof(rx_sof), .in_err(rx_err), .station(station_addr), .flg_d(flg_d)
  );

  pfd_decide u_decide (
    .clk(clk), .rst_n(rst_n), .fin(fin), .flg(flg_d), .crc_ok(crc_ok),
    .fwd_en(fwd_en), .full_duplex(full_duplex),
    .pause_req(pause_req), .pause_quanta(pause_quanta),
    .frame_done(frame_done), .frame_deliver(frame_deliver)
  );
endmodule

// File: tb/pause_rx_detect_bench.sv
module pause_rx_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, rx_err, crc_ok, fwd_en, full_duplex;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic        pause_req, frame_done, frame_deliver;
  logic [15:0] pause_quanta;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] fb [64];
  int flen;

  always #5 clk = ~clk;

  pause_rx_detect u_pause_rx_detect (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .crc_ok(crc_ok),
    .station_addr(station_addr), .fwd_en(fwd_en), .full_duplex(full_duplex),
    .pause_req(pause_req), .pause_quanta(pause_quanta),
    .frame_done(frame_done), .frame_deliver(frame_deliver)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit hdr_ok();
    logic [47:0] da;
    da = {fb[0], fb[1], fb[2], fb[3], fb[4], fb[5]};
    return (flen >= 18) && (da == station_addr || da == 48'h0180C2000001)
        && fb[12] == 8'h88 && fb[13] == 8'h08 && fb[14] == 8'h00 && fb[15] == 8'h01;
  endfunction

  // kind: 0 station, 1 group, 2 bad DA, 3 bad type, 4 bad opcode, 5 short, 6 random
  task automatic build(input int kind, input logic [15:0] qt);
    flen = (kind == 5) ? 6 + int'($urandom % 12) : 18 + int'($urandom % 30);
    for (int i = 0; i < 64; i++) fb[i] = 8'($urandom);
    if (kind != 6) begin
      for (int i = 0; i < 6; i++)
        fb[i] = (kind == 1) ? 8'(48'h0180C2000001 >> (8*(5-i))) : station_addr[8*(5-i) +: 8];
      fb[12] = 8'h88; fb[13] = 8'h08; fb[14] = 8'h00; fb[15] = 8'h01;
      fb[16] = qt[15:8]; fb[17] = qt[7:0];
    end
    if (kind == 2) begin int p; p = int'($urandom % 6); fb[p] = fb[p] ^ (8'h1 << ($urandom % 8)); end
    if (kind == 3) fb[12 + int'($urandom % 2)] ^= 8'h10;
    if (kind == 4) fb[14 + int'($urandom % 2)] ^= 8'h02;
  endtask

  task automatic send(input bit fwd, input bit fd, input bit crc, input int errpos, input string tag);
    bit good, exp_req, exp_del;
    logic [15:0] exp_q;
    good    = hdr_ok() && crc && (errpos < 0 || errpos >= flen) && fd;
    exp_req = good && !fwd;
    exp_del = !exp_req;
    exp_q   = {fb[16], fb[17]};
    fwd_en = fwd; full_duplex = fd;
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_data = fb[i];
      rx_sof = (i == 0); rx_eof = (i == flen - 1);
      rx_err = (i == errpos); crc_ok = crc;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    chk(frame_done == 1'b1, {tag, " R6 done"}, 32'(frame_done), 1);
    chk(pause_req == exp_req, {tag, " req"}, 32'(pause_req), 32'(exp_req));
    chk(frame_deliver == exp_del, {tag, " R7 deliver"}, 32'(frame_deliver), 32'(exp_del));
    if (exp_req) chk(pause_quanta == exp_q, {tag, " R5 quanta"}, 32'(pause_quanta), 32'(exp_q));
    @(negedge clk);
    chk(!pause_req && !frame_done, {tag, " R6 pulse"}, {30'd0, pause_req, frame_done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; crc_ok = 0;
    rx_data = 0; fwd_en = 0; full_duplex = 1;
    station_addr = 48'h02A1_B2C3_D4E5;
    repeat (3) @(negedge clk);
    chk({pause_req, frame_done, frame_deliver, pause_quanta} == '0, "R11 in reset",
        {13'd0, pause_req, frame_done, frame_deliver, pause_quanta}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pause_req, frame_done, frame_deliver, pause_quanta} == '0, "R11 after reset",
        {13'd0, pause_req, frame_done, frame_deliver, pause_quanta}, 0);

    build(0, 16'h1234); send(0, 1, 1, -1, "R1 station");
    build(1, 16'hFFFF); send(0, 1, 1, -1, "R2 group max");
    build(0, 16'h0000); send(0, 1, 1, -1, "R5 zero");
    build(0, 16'hA55A); send(1, 1, 1, -1, "R8 forward");
    build(1, 16'h0102); send(0, 0, 1, -1, "R9 half duplex");
    build(0, 16'h0F0F); send(0, 1, 0, -1, "R6 crc bad");
    build(0, 16'h0F0F); send(0, 1, 1, 3, "R6 err mark");
    build(0, 16'h7777); send(0, 1, 1, -1, "R6 after err");
    build(2, 16'h0404); send(0, 1, 1, -1, "R1 bad da");
    build(3, 16'h0505); send(0, 1, 1, -1, "R3 bad type");
    build(4, 16'h0606); send(0, 1, 1, -1, "R4 bad op");
    build(5, 16'h0707); send(0, 1, 1, -1, "R10 short");
    build(0, 16'hBEEF); flen = 18; send(0, 1, 1, -1, "R10 min length");

    for (int n = 0; n < 400; n++) begin
      int kind;
      kind = int'($urandom % 7);
      build(kind, 16'($urandom));
      send(($urandom % 4) == 0, ($urandom % 5) != 0, ($urandom % 6) != 0,
           (($urandom % 6) == 0) ? int'($urandom % 40) : -1, "R10 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule